// File: doc/BRIEF.md
# Register Rename Status Table

This block holds the floating-point register values of an out-of-order core, together with one producer tag per register. The tag names the execution station that will deliver the register's next value. A tag of zero means that no write is pending. At issue time, two source read ports report for each operand either a ready value or the tag the operand must wait for. A rename port then claims the destination register for the issuing station.

The block listens to the shared result bus, which carries a 64-bit result and the 4-bit tag of the station that produced it. A register takes a broadcast value only while its own recorded tag still equals the broadcast tag. A newer rename therefore silently retires the claim of an older writer, and that writer's late result is dropped. Reads see the table as it stands before the same cycle's rename. They also see any result being broadcast in that cycle, so a consumer never misses a value that arrives while it issues.

Top module: `rename_status_table`

## Requirements
- R1: While reset is held and afterwards until a write, every register reads with value 0 and tag 0.
- R2: A read of a register whose tag is 0 returns its stored value with tag 0.
- R3: A read of a register with a nonzero tag returns that tag, with the value output forced to all zeros.
- R4: A rename (issue valid, nonzero tag) sets the destination's tag from the next cycle on. A rename with tag 0 changes nothing.
- R5: A broadcast whose tag equals a register's nonzero tag stores the bus data in that register and returns its tag to 0 at the same clock edge.
- R6: A broadcast whose tag differs from a register's tag leaves that register unchanged. This covers a superseded writer's tag and tag 0 sent to a blank register.
- R7: When a rename and a matching broadcast hit the same register in one cycle, the register takes the new tag and keeps its old value.
- R8: A read in the same cycle as a matching broadcast returns the bus data with tag 0.
- R9: A read of a register renamed in the same cycle returns the state from before that rename.
- R10: The two read ports answer independently for different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a_addr | input | 4 | Register index for read port A |
| src_b_addr | input | 4 | Register index for read port B |
| src_a_value | output | 64 | Port A value, zero while pending |
| src_a_tag | output | 4 | Port A producer tag, zero when ready |
| src_b_value | output | 64 | Port B value, zero while pending |
| src_b_tag | output | 4 | Port B producer tag, zero when ready |
| iss_valid | input | 1 | Rename request |
| iss_dst_addr | input | 4 | Destination register to claim |
| iss_tag | input | 4 | Tag of the issuing station |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | 4 | Tag of the producing station |
| bus_data | input | 64 | Result data |

## Verification
The bench drives a superseded writer's broadcast after a second rename of the same register. A design that matched on any tag ever given to the register would overwrite the newer pending value. It collides a rename with a matching broadcast on one register in one cycle. A design that let the broadcast win would leave the register blank, holding stale data. It reads a register in the cycle its result arrives, where a design without the bypass reports a tag that will never be broadcast again. It also reads a register in the cycle it is renamed, where a design forwarding the new tag would make an instruction wait on itself. It further sends tag 0 on the bus and issues with tag 0, both of which must leave the table untouched.

// File: rtl/rst_pkg.sv
package rst_pkg;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 64;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [DATA_W-1:0] data_t;

  // A pending register claims a broadcast only when its own tag is on the bus.
  function automatic logic claims(input tag_t status, input logic bvalid, input tag_t btag);
    return bvalid && (status != '0) && (status == btag);
  endfunction

  // Value shown to a reader: zero whenever a tag is returned instead.
  function automatic data_t shown_value(input tag_t tag, input data_t value);
    return (tag != '0) ? '0 : value;
  endfunction
endpackage

// File: rtl/rst_reg_slot.sv
module rst_reg_slot
  import rst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ren_hit,
  input  tag_t  ren_tag,
  input  logic  bus_hit,
  input  data_t bus_data,
  output data_t value_q,
  output tag_t  status_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q  <= '0;
      status_q <= '0;
    end else if (ren_hit) begin
      status_q <= ren_tag;          // newest writer wins, old result dropped
    end else if (bus_hit) begin
      value_q  <= bus_data;
      status_q <= '0;
    end
  end
endmodule

// File: rtl/rst_read_port.sv
module rst_read_port
  import rst_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int AW = $clog2(NUM_REGS)
)(
  input  logic [AW-1:0]              addr,
  input  tag_t  [NUM_REGS-1:0]       status_q,
  input  data_t [NUM_REGS-1:0]       value_q,
  input  logic                       bus_valid,
  input  tag_t                       bus_tag,
  input  data_t                      bus_data,
  output data_t                      rd_value,
  output tag_t                       rd_tag
);
  tag_t  cur_tag;
  data_t cur_val;
  logic  bypass;

  always_comb begin
    cur_tag = status_q[addr];
    cur_val = value_q[addr];
    bypass  = claims(cur_tag, bus_valid, bus_tag);
    rd_tag  = bypass ? '0 : cur_tag;
    rd_value = bypass ? bus_data : shown_value(cur_tag, cur_val);
  end
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
  import rst_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int AW = $clog2(NUM_REGS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     src_a_addr,
  input  logic [AW-1:0]     src_b_addr,
  output logic [DATA_W-1:0] src_a_value,
  output logic [TAG_W-1:0]  src_a_tag,
  output logic [DATA_W-1:0] src_b_value,
  output logic [TAG_W-1:0]  src_b_tag,
  input  logic              iss_valid,
  input  logic [AW-1:0]     iss_dst_addr,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data
);
  tag_t  [NUM_REGS-1:0] status_q;
  data_t [NUM_REGS-1:0] value_q;
  logic  [NUM_REGS-1:0] ren_hit;   // named event: slot claimed by a new writer
  logic  [NUM_REGS-1:0] bus_hit;   // named event: slot matches the broadcast

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    assign ren_hit[i] = iss_valid && (iss_tag != '0) && (iss_dst_addr == AW'(i));
    assign bus_hit[i] = claims(status_q[i], bus_valid, bus_tag);

    rst_reg_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .ren_hit  (ren_hit[i]),
      .ren_tag  (iss_tag),
      .bus_hit  (bus_hit[i]),
      .bus_data (bus_data),
      .value_q  (value_q[i]),
      .status_q (status_q[i])
    );
  end

  rst_read_port #(.NUM_REGS(NUM_REGS)) u_rd_a (
    .addr(src_a_addr), .status_q(status_q), .value_q(value_q),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .rd_value(src_a_value), .rd_tag(src_a_tag)
  );

  rst_read_port #(.NUM_REGS(NUM_REGS)) u_rd_b (
    .addr(src_b_addr), .status_q(status_q), .value_q(value_q),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .rd_value(src_b_value), .rd_tag(src_b_tag)
  );
endmodule

// File: rtl/rst_checker.sv
module rst_checker
  import rst_pkg::*;
#(
  parameter int NUM_REGS = 16
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic  [NUM_REGS-1:0] ren_hit,
  input logic  [NUM_REGS-1:0] bus_hit,
  input tag_t  [NUM_REGS-1:0] status_q,
  input data_t [NUM_REGS-1:0] value_q,
  input tag_t                 iss_tag,
  input data_t                bus_data,
  input tag_t                 src_a_tag,
  input data_t                src_a_value,
  input tag_t                 src_b_tag,
  input data_t                src_b_value
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    p_rename_sets_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ren_hit[i] |=> status_q[i] == $past(iss_tag));
    p_rename_keeps_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ren_hit[i] |=> $stable(value_q[i]));
    p_claim_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_hit[i] && !ren_hit[i]) |=> (status_q[i] == '0) && (value_q[i] == $past(bus_data)));
    p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_hit[i] && !ren_hit[i]) |=> $stable(value_q[i]) && $stable(status_q[i]));
  end

  p_rename_single_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ren_hit));
  p_pending_a_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_tag != '0) |-> (src_a_value == '0));
  p_pending_b_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_b_tag != '0) |-> (src_b_value == '0));
endmodule

bind rename_status_table rst_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_hit(ren_hit), .bus_hit(bus_hit),
  .status_q(status_q), .value_q(value_q), .iss_tag(iss_tag), .bus_data(bus_data),
  .src_a_tag(src_a_tag), .src_a_value(src_a_value),
  .src_b_tag(src_b_tag), .src_b_value(src_b_value)
);

// File: tb/rename_status_table_tb.sv
module rename_status_table_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_a_addr = '0, src_b_addr = '0;
  logic [63:0] src_a_value, src_b_value;
  logic [3:0]  src_a_tag, src_b_tag;
  logic        iss_valid = 1'b0;
  logic [3:0]  iss_dst_addr = '0, iss_tag = '0;
  logic        bus_valid = 1'b0;
  logic [3:0]  bus_tag = '0;
  logic [63:0] bus_data = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_status_table u_dut (
    .clk(clk), .rst_n(rst_n),
    .src_a_addr(src_a_addr), .src_b_addr(src_b_addr),
    .src_a_value(src_a_value), .src_a_tag(src_a_tag),
    .src_b_value(src_b_value), .src_b_tag(src_b_tag),
    .iss_valid(iss_valid), .iss_dst_addr(iss_dst_addr), .iss_tag(iss_tag),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive controls just after a falling edge; outputs settle 1 time unit later.
  task automatic drive(input logic iv, input logic [3:0] dst, input logic [3:0] it,
                       input logic bv, input logic [3:0] bt, input logic [63:0] bd);
    @(negedge clk);
    iss_valid = iv; iss_dst_addr = dst; iss_tag = it;
    bus_valid = bv; bus_tag = bt; bus_data = bd;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 64'd0);
  endtask

  task automatic read_a(input logic [3:0] r, input string req, input logic [63:0] ev, input logic [3:0] et);
    src_a_addr = r; #1;
    chk(req, "port A value", src_a_value, ev);
    chk(req, "port A tag", {60'd0, src_a_tag}, {60'd0, et});
  endtask

  task automatic t_reset();
    src_a_addr = 4'd0; src_b_addr = 4'd15; #1;
    chk("R1", "r0 value", src_a_value, 64'd0);
    chk("R1", "r0 tag", {60'd0, src_a_tag}, 64'd0);
    chk("R1", "r15 value", src_b_value, 64'd0);
    chk("R1", "r15 tag", {60'd0, src_b_tag}, 64'd0);
  endtask

  task automatic t_rename_then_write();
    drive(1'b1, 4'd3, 4'd5, 1'b0, 4'd0, 64'd0);
    idle();
    read_a(4'd3, "R3", 64'd0, 4'd5);
    drive(1'b0, 4'd0, 4'd0, 1'b1, 4'd5, 64'h1111_2222_3333_4444);
    read_a(4'd3, "R8", 64'h1111_2222_3333_4444, 4'd0);
    idle();
    read_a(4'd3, "R5", 64'h1111_2222_3333_4444, 4'd0);
  endtask

  task automatic t_waw();
    drive(1'b1, 4'd4, 4'd2, 1'b0, 4'd0, 64'd0);
    drive(1'b1, 4'd4, 4'd7, 1'b0, 4'd0, 64'd0);
    drive(1'b0, 4'd0, 4'd0, 1'b1, 4'd2, 64'hAAAA);
    read_a(4'd4, "R6", 64'd0, 4'd7);
    idle();
    read_a(4'd4, "R6", 64'd0, 4'd7);
    drive(1'b0, 4'd0, 4'd0, 1'b1, 4'd7, 64'hBBBB);
    idle();
    read_a(4'd4, "R5", 64'hBBBB, 4'd0);
  endtask

  task automatic t_tag0_bus();
    drive(1'b0, 4'd0, 4'd0, 1'b1, 4'd0, 64'hCCCC);
    read_a(4'd3, "R6", 64'h1111_2222_3333_4444, 4'd0);
    idle();
    read_a(4'd3, "R6", 64'h1111_2222_3333_4444, 4'd0);
    read_a(4'd9, "R6", 64'd0, 4'd0);
  endtask

  task automatic t_collision();
    drive(1'b1, 4'd5, 4'd3, 1'b0, 4'd0, 64'd0);
    drive(1'b1, 4'd5, 4'd9, 1'b1, 4'd3, 64'hDDDD);
    idle();
    read_a(4'd5, "R7", 64'd0, 4'd9);
    drive(1'b0, 4'd0, 4'd0, 1'b1, 4'd9, 64'hEEEE);
    idle();
    read_a(4'd5, "R7", 64'hEEEE, 4'd0);
  endtask

  task automatic t_war_dual();
    drive(1'b1, 4'd3, 4'd6, 1'b0, 4'd0, 64'd0);
    src_a_addr = 4'd3; src_b_addr = 4'd4; #1;
    chk("R9", "same-cycle read value", src_a_value, 64'h1111_2222_3333_4444);
    chk("R9", "same-cycle read tag", {60'd0, src_a_tag}, 64'd0);
    chk("R10", "port B value", src_b_value, 64'hBBBB);
    chk("R10", "port B tag", {60'd0, src_b_tag}, 64'd0);
    idle();
    read_a(4'd3, "R4", 64'd0, 4'd6);
    drive(1'b0, 4'd0, 4'd0, 1'b1, 4'd6, 64'h6666);
    idle();
    read_a(4'd3, "R5", 64'h6666, 4'd0);
    read_a(4'd4, "R6", 64'hBBBB, 4'd0);
  endtask

  task automatic t_issue_tag0();
    drive(1'b1, 4'd4, 4'd0, 1'b0, 4'd0, 64'd0);
    idle();
    read_a(4'd4, "R4", 64'hBBBB, 4'd0);
    read_a(4'd4, "R2", 64'hBBBB, 4'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rename_then_write();
    t_waw();
    t_tag0_bus();
    t_collision();
    t_war_dual();
    t_issue_tag0();
    idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule